// File: doc/BRIEF.md
# Dual Event Counter with Selectable Compare Behaviour

The block holds two event counters, each paired with a compare register. A single mode field decides what the compare registers are for.

- In threshold mode, a counter that climbs above its compare value raises a sticky status flag and a registered event line. Each of the two can be enabled on its own.
- In high-water mode, each compare register tracks the largest value its counter has reached.
- In address-range mode, the two compare registers bound an address window. Counting on both counters is allowed only while the incoming transaction address lies inside that window.

Each counter word is a 31-bit count with a sticky overflow flag above it. Software can preload a counter, and a preloaded value survives the next sample-period start. That lets software place the counter just below overflow before a measurement begins. Without a preload, every sample-period start clears the counter. Software reaches the registers through a simple word-wide write strobe and a combinational read port. Event sources are selected upstream and arrive as one increment request per counter.

Top module: `perf_cmp_counter`

## Requirements
- R1: After reset both count words read 0, both compare registers read 0xFFFFFFFF, the control register reads 0 and both event outputs are low.
- R2: Register index 0 is control, 1 is count word 0, 2 is compare 0, 3 is count word 1 and 4 is compare 1. A write takes effect at the clock edge where `reg_wr_en` is high. Reads are combinational from `reg_addr`.
- R3: A count word holds the count in bits 30:0 and the overflow flag in bit 31. An accepted increment adds one to the count. An increment from count 0x7FFFFFFF gives count 0 and sets the overflow flag in the same cycle. The overflow flag stays set through further increments.
- R4: Writing 1 to control bit 6 (counter 0) or bit 7 (counter 1) clears that counter's overflow flag and leaves its count bits unchanged.
- R5: At a `period_start` pulse, a counter is cleared to 0 unless it was written by software since the previous pulse. A written counter keeps its value at that pulse, and the next pulse clears it again unless software has written it once more.
- R6: In a single cycle, a software write to a count word takes priority over `period_start`, and `period_start` takes priority over an increment. The request that loses has no effect.
- R7: Threshold mode is mode 00 in control bits 1:0, and the reserved code 11 behaves the same way. If an applied increment makes the new 32-bit word, overflow bit included, greater than the compare register, then the counter's status bit is set when control bit 2 is 1, and its event output is raised when control bit 3 is 1.
- R8: Status bits and event outputs are sticky. Writing 1 to control bit 4 (counter 0) or bit 5 (counter 1) clears both the status bit and the event output of that counter. Status bits for counters 0 and 1 read back in control bits 4 and 5.
- R9: High-water mode is mode 01. An applied increment whose new word exceeds the compare register loads that word into the compare register. No status bit or event output is set in this mode.
- R10: Address-range mode is mode 10. With a = `txn_addr[38:7]`, the window is open when a > compare 0 and a <= compare 1. Increments on both counters are accepted only while the window is open. No status bit or event output is set in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| evt_inc | input | 2 | Increment request, one bit per counter |
| txn_addr | input | 39 | Transaction address used by the range window |
| period_start | input | 1 | Sample-period start pulse |
| evt_out | output | 2 | Registered sticky event line per counter |

## Verification
Every register, status bit and event output of this block changes at the first rising edge after the stimulus is presented, and read data follows `reg_addr` within the same cycle. The bench therefore drives every input on the falling edge and holds it across exactly one rising edge. It samples results on the next falling edge, by which time the counter, compare register, status bit and event line have all settled. Priority cases and the range window are arranged so that the losing request or the rejected increment would produce a different count word if it had taken effect.

// File: rtl/pcc_pkg.sv
// Package: shared encodings for the dual compare counter.
// Assumes control register bit positions below are fixed by the software view.
package pcc_pkg;

    typedef enum logic [1:0] {
        MODE_THRESH = 2'b00,
        MODE_HWM    = 2'b01,
        MODE_RANGE  = 2'b10,
        MODE_RSVD   = 2'b11
    } cmp_mode_e;

    localparam int CTRL_MODE_LSB  = 0;
    localparam int CTRL_STEN_BIT  = 2;
    localparam int CTRL_PINEN_BIT = 3;
    localparam int CTRL_STCLR_LSB = 4;
    localparam int CTRL_OVCLR_LSB = 6;
    localparam int CTRL_USED_W    = 8;

    localparam int REG_CTRL = 0;

endpackage

// File: rtl/pcc_ctrl.sv
// Module: control register. Holds the compare mode and the two output enables,
// and turns write-one-to-clear bits into per-counter clear pulses.
// Assumes NUM_CNT <= 2, which the fixed control bit layout allows.
module pcc_ctrl
    import pcc_pkg::*;
#(
    parameter int NUM_CNT = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctrl_wr,
    input  logic [CTRL_USED_W-1:0] wdata,
    output cmp_mode_e              mode,
    output logic                   st_en,
    output logic                   pin_en,
    output logic [NUM_CNT-1:0]     st_clr,
    output logic [NUM_CNT-1:0]     ovf_clr
);

    // Purpose: store mode and enable fields on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= MODE_THRESH;
            st_en  <= 1'b0;
            pin_en <= 1'b0;
        end else if (ctrl_wr) begin
            mode   <= cmp_mode_e'(wdata[CTRL_MODE_LSB +: 2]);
            st_en  <= wdata[CTRL_STEN_BIT];
            pin_en <= wdata[CTRL_PINEN_BIT];
        end
    end

    // Purpose: decode clear pulses, valid only in the write cycle.
    always_comb begin
        st_clr  = ctrl_wr ? wdata[CTRL_STCLR_LSB +: NUM_CNT] : '0;
        ovf_clr = ctrl_wr ? wdata[CTRL_OVCLR_LSB +: NUM_CNT] : '0;
    end

endmodule

// File: rtl/pcc_window.sv
// Module: address window test. Open when the address field lies above the
// low bound and at or below the high bound. Purely combinational.
// Assumes the address field and the bounds share one width.
module pcc_window #(
    parameter int W = 32
) (
    input  logic [W-1:0] addr_field,
    input  logic [W-1:0] lo_bound,
    input  logic [W-1:0] hi_bound,
    output logic         in_win
);

    // Purpose: unsigned range compare, exclusive low and inclusive high.
    always_comb begin
        in_win = (addr_field > lo_bound) && (addr_field <= hi_bound);
    end

endmodule

// File: rtl/pcc_counter.sv
// Module: one counter slice. Holds the count word (overflow flag on top), its
// compare register, the preload marker, the sticky status bit and the event
// line. Priority within a cycle: software write, then period start, then increment.
// Assumes win_ok is only meaningful in range mode.
module pcc_counter
    import pcc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmp_mode_e        mode,
    input  logic             st_en,
    input  logic             pin_en,
    input  logic             cnt_wr,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             period_start,
    input  logic             inc_req,
    input  logic             win_ok,
    input  logic             ovf_clr,
    input  logic             st_clr,
    output logic [CNT_W-1:0] cnt_word,
    output logic [CNT_W-1:0] cmp_word,
    output logic             pre_flag,
    output logic             status,
    output logic             evt
);

    localparam int VAL_W = CNT_W - 1;

    logic [VAL_W-1:0] cnt_q;
    logic             ovf_q;
    logic [CNT_W-1:0] cmp_q;
    logic             pre_q;
    logic             is_thresh;
    logic             inc_ok;
    logic             applied;
    logic [VAL_W-1:0] nxt_cnt;
    logic             nxt_ovf;
    logic [CNT_W-1:0] nxt_word;
    logic             above;

    // Purpose: qualify the increment and form the next word and compare result.
    always_comb begin
        is_thresh = (mode == MODE_THRESH) || (mode == MODE_RSVD);
        inc_ok    = inc_req && ((mode != MODE_RANGE) || win_ok);
        applied   = inc_ok && !cnt_wr && !period_start;
        nxt_cnt   = cnt_q + 1'b1;
        nxt_ovf   = ovf_q | (&cnt_q);
        nxt_word  = {nxt_ovf, nxt_cnt};
        above     = nxt_word > cmp_q;
    end

    // Purpose: count word, overflow flag and preload marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
            pre_q <= 1'b0;
        end else if (cnt_wr) begin
            cnt_q <= wdata[VAL_W-1:0];
            ovf_q <= wdata[CNT_W-1];
            pre_q <= 1'b1;
        end else begin
            if (period_start) begin
                if (pre_q) begin
                    pre_q <= 1'b0;
                end else begin
                    cnt_q <= '0;
                    ovf_q <= 1'b0;
                end
            end else if (inc_ok) begin
                cnt_q <= nxt_cnt;
                ovf_q <= nxt_ovf;
            end
            if (ovf_clr) begin
                ovf_q <= 1'b0;
            end
        end
    end

    // Purpose: compare register, written by software or raised in high-water mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '1;
        end else if (cmp_wr) begin
            cmp_q <= wdata;
        end else if ((mode == MODE_HWM) && applied && above) begin
            cmp_q <= nxt_word;
        end
    end

    // Purpose: sticky status bit and event line for threshold mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= 1'b0;
            evt    <= 1'b0;
        end else if (st_clr) begin
            status <= 1'b0;
            evt    <= 1'b0;
        end else if (is_thresh && applied && above) begin
            if (st_en) begin
                status <= 1'b1;
            end
            if (pin_en) begin
                evt <= 1'b1;
            end
        end
    end

    // Purpose: drive outputs from state.
    always_comb begin
        cnt_word = {ovf_q, cnt_q};
        cmp_word = cmp_q;
        pre_flag = pre_q;
    end

endmodule

// File: rtl/perf_cmp_counter.sv
// Module: top of the dual compare counter. Decodes register writes, muxes
// register reads, extracts the address field and wires the two counter slices
// to the shared control register and the address window.
// Assumes exactly two counters: the window uses compare 0 as the low bound
// and compare 1 as the high bound.
module perf_cmp_counter
    import pcc_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int ADDR_W   = 39,
    parameter int ADDR_LSB = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    input  logic [1:0]        evt_inc,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic              period_start,
    output logic [1:0]        evt_out
);

    localparam int NUM_CNT = 2;
    localparam int FIELD_W = ADDR_W - ADDR_LSB;

    cmp_mode_e           mode;
    logic                st_en;
    logic                pin_en;
    logic                ctrl_wr;
    logic [NUM_CNT-1:0]  st_clr;
    logic [NUM_CNT-1:0]  ovf_clr;
    logic [NUM_CNT-1:0]  cnt_wr;
    logic [NUM_CNT-1:0]  cmp_wr;
    logic [CNT_W-1:0]    cnt_word [NUM_CNT];
    logic [CNT_W-1:0]    cmp_word [NUM_CNT];
    logic [NUM_CNT-1:0]  pre_flag;
    logic [NUM_CNT-1:0]  status;
    logic [NUM_CNT-1:0]  evt;
    logic [FIELD_W-1:0]  addr_field;
    logic                in_win;

    // Purpose: decode the control write strobe.
    always_comb begin
        ctrl_wr    = reg_wr_en && (reg_addr == 3'(REG_CTRL));
        addr_field = txn_addr[ADDR_W-1:ADDR_LSB];
    end

    pcc_ctrl #(
        .NUM_CNT (NUM_CNT)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .wdata   (reg_wdata[CTRL_USED_W-1:0]),
        .mode    (mode),
        .st_en   (st_en),
        .pin_en  (pin_en),
        .st_clr  (st_clr),
        .ovf_clr (ovf_clr)
    );

    pcc_window #(
        .W (FIELD_W)
    ) u_window (
        .addr_field (addr_field),
        .lo_bound   (cmp_word[0][FIELD_W-1:0]),
        .hi_bound   (cmp_word[1][FIELD_W-1:0]),
        .in_win     (in_win)
    );

    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        // Purpose: decode per-counter write strobes.
        always_comb begin
            cnt_wr[gi] = reg_wr_en && (reg_addr == 3'(1 + 2 * gi));
            cmp_wr[gi] = reg_wr_en && (reg_addr == 3'(2 + 2 * gi));
        end

        pcc_counter #(
            .CNT_W (CNT_W)
        ) u_counter (
            .clk          (clk),
            .rst_n        (rst_n),
            .mode         (mode),
            .st_en        (st_en),
            .pin_en       (pin_en),
            .cnt_wr       (cnt_wr[gi]),
            .cmp_wr       (cmp_wr[gi]),
            .wdata        (reg_wdata),
            .period_start (period_start),
            .inc_req      (evt_inc[gi]),
            .win_ok       (in_win),
            .ovf_clr      (ovf_clr[gi]),
            .st_clr       (st_clr[gi]),
            .cnt_word     (cnt_word[gi]),
            .cmp_word     (cmp_word[gi]),
            .pre_flag     (pre_flag[gi]),
            .status       (status[gi]),
            .evt          (evt[gi])
        );
    end

    // Purpose: combinational register read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            3'd0: begin
                reg_rdata[CTRL_MODE_LSB +: 2]        = mode;
                reg_rdata[CTRL_STEN_BIT]             = st_en;
                reg_rdata[CTRL_PINEN_BIT]            = pin_en;
                reg_rdata[CTRL_STCLR_LSB +: NUM_CNT] = status;
            end
            3'd1:    reg_rdata = cnt_word[0];
            3'd2:    reg_rdata = cmp_word[0];
            3'd3:    reg_rdata = cnt_word[1];
            3'd4:    reg_rdata = cmp_word[1];
            default: reg_rdata = '0;
        endcase
    end

    // Purpose: event outputs come straight from the registered event bits.
    always_comb begin
        evt_out = evt;
    end

endmodule

// File: rtl/pcc_checker.sv
// Module: assertion checker for counter 0 of the top, attached by bind.
// Assumes it sees the top's ports and counter 0's internal state.
module pcc_checker
    import pcc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_en,
    input logic [2:0]       reg_addr,
    input logic [CNT_W-1:0] reg_wdata,
    input logic             period_start,
    input logic [1:0]       evt_inc,
    input logic [1:0]       evt_out,
    input cmp_mode_e        mode,
    input logic             in_win,
    input logic             pre0,
    input logic [CNT_W-1:0] cnt0,
    input logic [CNT_W-1:0] cmp0
);

    logic ctrl_w, cnt0_w, cmp0_w;

    // Purpose: write strobes seen at the ports.
    always_comb begin
        ctrl_w = reg_wr_en && (reg_addr == 3'd0);
        cnt0_w = reg_wr_en && (reg_addr == 3'd1);
        cmp0_w = reg_wr_en && (reg_addr == 3'd2);
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt0[CNT_W-1] && !(ctrl_w && reg_wdata[CTRL_OVCLR_LSB]) && !cnt0_w && !(period_start && !pre0))
        |=> cnt0[CNT_W-1]); // R3

    AST_PERIOD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && !pre0 && !cnt0_w) |=> (cnt0 == '0)); // R5

    AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_out[0] && !(ctrl_w && reg_wdata[CTRL_STCLR_LSB])) |=> evt_out[0]); // R8

    AST_HWM_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_HWM) && !cmp0_w) |=> (cmp0 >= $past(cmp0))); // R9

    AST_RANGE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_RANGE) && evt_inc[0] && !in_win && !cnt0_w && !period_start && !ctrl_w)
        |=> $stable(cnt0)); // R10

endmodule

bind perf_cmp_counter pcc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_en    (reg_wr_en),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .period_start (period_start),
    .evt_inc      (evt_inc),
    .evt_out      (evt_out),
    .mode         (mode),
    .in_win       (in_win),
    .pre0         (pre_flag[0]),
    .cnt0         (cnt_word[0]),
    .cmp0         (cmp_word[0])
);

// File: tb/perf_cmp_counter_bench.sv
// Bench: vector table for threshold mode, then directed tests.
module perf_cmp_counter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  evt_inc = '0;
    logic [38:0] txn_addr = '0;
    logic        period_start = 1'b0;
    logic [1:0]  evt_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    perf_cmp_counter u_perf_cmp_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr_en    (reg_wr_en),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .evt_inc      (evt_inc),
        .txn_addr     (txn_addr),
        .period_start (period_start),
        .evt_out      (evt_out)
    );

    // Threshold-mode vectors: preload, compare, increments, expected word, expected status.
    localparam int NV = 5;
    localparam logic [31:0] V_PRE [NV] = '{32'd0, 32'd0, 32'h7FFF_FFFE, 32'd10, 32'h7FFF_FFFF};
    localparam logic [31:0] V_CMP [NV] = '{32'd5, 32'd5, 32'h7FFF_FFFF, 32'd10, 32'hFFFF_FFFF};
    localparam int          V_N   [NV] = '{3, 6, 2, 0, 1};
    localparam logic [31:0] V_CNT [NV] = '{32'd3, 32'd6, 32'h8000_0000, 32'd10, 32'h8000_0000};
    localparam logic        V_ST  [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("[TB] FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic incs(input logic [1:0] m, input int n);
        for (int k = 0; k < n; k++) begin
            evt_inc = m;
            @(posedge clk); @(negedge clk);
            evt_inc = '0;
        end
    endtask

    task automatic pulse_period();
        period_start = 1'b1;
        @(posedge clk); @(negedge clk);
        period_start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("[TB] FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd1, d); check("R1 cnt0", d, 32'd0);
        rd(3'd3, d); check("R1 cnt1", d, 32'd0);
        rd(3'd2, d); check("R1 cmp0", d, 32'hFFFF_FFFF);
        rd(3'd4, d); check("R1 cmp1", d, 32'hFFFF_FFFF);
        rd(3'd0, d); check("R1 ctrl", d, 32'd0);
        check("R1 evt", {30'd0, evt_out}, 32'd0);

        // R7 vector table, threshold mode with status and pin enabled
        for (int v = 0; v < NV; v++) begin
            wr(3'd0, 32'hFC);
            wr(3'd2, V_CMP[v]);
            wr(3'd1, V_PRE[v]);
            incs(2'b01, V_N[v]);
            rd(3'd1, d); check($sformatf("R7 vec%0d count", v), d, V_CNT[v]);
            rd(3'd0, d); check($sformatf("R7 vec%0d status", v), {31'd0, d[4]}, {31'd0, V_ST[v]});
            check($sformatf("R7 vec%0d evt", v), {31'd0, evt_out[0]}, {31'd0, V_ST[v]});
        end

        // R3 wrap and sticky overflow, then R4 overflow clear
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd1, 32'h7FFF_FFFF);
        incs(2'b01, 3);
        rd(3'd1, d); check("R3 wrap sticky", d, 32'h8000_0002);
        wr(3'd0, 32'h4C);
        rd(3'd1, d); check("R4 ovf clear", d, 32'h0000_0002);

        // R8 sticky status then clear; mode 11 behaves as threshold
        wr(3'd0, 32'h3F);
        wr(3'd2, 32'd0);
        wr(3'd1, 32'd0);
        incs(2'b01, 1);
        check("R8 evt set mode11", {31'd0, evt_out[0]}, 32'd1);
        incs(2'b01, 2);
        check("R8 evt held", {31'd0, evt_out[0]}, 32'd1);
        wr(3'd0, 32'h1F);
        check("R8 evt cleared", {31'd0, evt_out[0]}, 32'd0);
        rd(3'd0, d); check("R8 status cleared", {31'd0, d[4]}, 32'd0);

        // R7 pin only, status disabled
        wr(3'd0, 32'h38);
        wr(3'd1, 32'd0);
        incs(2'b01, 1);
        rd(3'd0, d); check("R7 status disabled", {31'd0, d[4]}, 32'd0);
        check("R7 pin enabled", {31'd0, evt_out[0]}, 32'd1);

        // R7 counter 1 independent
        wr(3'd0, 32'hFC);
        wr(3'd4, 32'd1);
        wr(3'd3, 32'd0);
        incs(2'b10, 2);
        rd(3'd0, d); check("R7 cnt1 status", {30'd0, d[5:4]}, 32'd2);
        check("R7 cnt1 evt", {30'd0, evt_out}, 32'd2);
        wr(3'd0, 32'h2C);
        check("R8 cnt1 evt clear", {30'd0, evt_out}, 32'd0);

        // R5 preload survives one period start only
        wr(3'd1, 32'd100);
        pulse_period();
        rd(3'd1, d); check("R5 preload kept", d, 32'd100);
        incs(2'b01, 1);
        pulse_period();
        rd(3'd1, d); check("R5 cleared next period", d, 32'd0);

        // R6 write beats increment
        evt_inc = 2'b01;
        wr(3'd1, 32'd50);
        evt_inc = '0;
        rd(3'd1, d); check("R6 write over inc", d, 32'd50);
        // R6 period start beats increment (counter preloaded by the write above)
        pulse_period();
        incs(2'b01, 1);
        evt_inc = 2'b01; period_start = 1'b1;
        @(posedge clk); @(negedge clk);
        evt_inc = '0; period_start = 1'b0;
        rd(3'd1, d); check("R6 period over inc", d, 32'd0);
        // R6 write beats period start
        period_start = 1'b1;
        wr(3'd1, 32'd7);
        period_start = 1'b0;
        rd(3'd1, d); check("R6 write over period", d, 32'd7);

        // R9 high-water mode
        wr(3'd0, 32'hFD);
        wr(3'd2, 32'd3);
        wr(3'd1, 32'd0);
        incs(2'b01, 5);
        rd(3'd2, d); check("R9 cmp raised", d, 32'd5);
        rd(3'd0, d); check("R9 no status", {31'd0, d[4]}, 32'd0);
        wr(3'd1, 32'd1);
        incs(2'b01, 1);
        rd(3'd2, d); check("R9 cmp not lowered", d, 32'd5);

        // R10 address range mode
        wr(3'd0, 32'hFE);
        wr(3'd2, 32'h100);
        wr(3'd4, 32'h200);
        wr(3'd1, 32'd0);
        wr(3'd3, 32'd0);
        txn_addr = {32'h100, 7'd0}; incs(2'b11, 1);
        txn_addr = {32'h101, 7'd0}; incs(2'b11, 1);
        txn_addr = {32'h200, 7'd0}; incs(2'b11, 1);
        txn_addr = {32'h201, 7'd0}; incs(2'b11, 1);
        txn_addr = {32'h150, 7'h7F}; incs(2'b01, 1);
        rd(3'd1, d); check("R10 cnt0 gated", d, 32'd3);
        rd(3'd3, d); check("R10 cnt1 gated", d, 32'd2);
        rd(3'd0, d); check("R10 no status", {30'd0, d[5:4]}, 32'd0);
        check("R10 no evt", {30'd0, evt_out}, 32'd0);

        // R2 control read-back of mode and enables
        rd(3'd0, d); check("R2 ctrl readback", {24'd0, d[7:0]}, 32'h0E);
        rd(3'd5, d); check("R2 unmapped index", d, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule